// File: doc/BRIEF.md
# Schedule-Ordered 2-D Iteration Index Generator

This block produces the (i, j) index pairs that feed a loop-body datapath that evaluates a two-dimensional nested loop. For a run it covers the rectangle from (1,1) to (M,N) one pair per clock, visiting every pair once. The order of the visit is picked per run. It can go row by row, column by column, or by anti-diagonal wavefronts. In wavefront order all pairs on one diagonal (equal i+j) leave before the next diagonal starts, which suits a datapath that reads the neighbours (i-1, j) and (i, j-1) computed on earlier diagonals.

A run starts with a one-cycle start pulse that captures the bounds and the order. The first pair appears on the next cycle. A done flag marks the final pair (M,N), and the output goes idle after that pair has been consumed. A stall input holds the current pair and all internal state so that a slower consumer can apply back-pressure.

Top module: `sched_idx_gen`

## Requirements
- R1: After reset, valid_o and done_o are low, and they stay low until a start is accepted.
- R2: A start_i pulse with stall_i low captures m_i, n_i and mode_i. On the next cycle valid_o is high with pair (1,1). A start accepted during a run abandons that run and begins the new one.
- R3: Mode 0 (row order): j advances fastest. After (i,N) comes (i+1,1).
- R4: Mode 1 (column order): i advances fastest. After (M,j) comes (1,j+1).
- R5: Mode 2 (wavefront order): pairs are grouped by ascending i+j, and within one diagonal i increases. Positions outside 1..M by 1..N cost no cycle.
- R6: Mode 3 is reserved and traverses in row order, the same as mode 0.
- R7: Without stalls, a run holds valid_o high for exactly M*N consecutive cycles. Each pair with 1<=i<=M and 1<=j<=N appears exactly once.
- R8: done_o is high only while the final pair (M,N) is presented. On the cycle after that pair is consumed, valid_o is low.
- R9: While stall_i is high, i_o, j_o, valid_o and done_o hold their values, the traversal does not advance, and start_i is ignored.
- R10: Changes to m_i, n_i and mode_i after a start is accepted have no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a run with the bounds and order on the inputs |
| stall_i | input | 1 | Hold the current pair and all state |
| mode_i | input | 2 | Order: 0 row, 1 column, 2 wavefront, 3 row |
| m_i | input | IDX_W | Upper bound M of index i (1 or more) |
| n_i | input | IDX_W | Upper bound N of index j (1 or more) |
| valid_o | output | 1 | i_o and j_o carry a pair |
| i_o | output | IDX_W | Current i index |
| j_o | output | IDX_W | Current j index |
| done_o | output | 1 | The current pair is the final pair (M,N) |

## Verification
The assertions assume that every accepted start carries bounds of at least one. They also assume that the reserved mode behaves as row order, and they check step rules against a copy of the bounds and mode taken at start. The bench therefore never starts with a zero bound, and it runs mode 3 only to confirm that it matches row order. The bench also drives m_i, n_i and mode_i with unrelated values once a start is taken, so that nothing depends on those inputs being held. It raises start only while stall is low, except in the one check that start is ignored during a stall.

// File: rtl/sched_idx_pkg.sv
// Package: shared order encoding for the schedule-ordered index generator.
// Assumes: mode values are decoded only here; value 3 is reserved.
package sched_idx_pkg;
    typedef enum logic [1:0] {
        ORD_ROW  = 2'd0,
        ORD_COL  = 2'd1,
        ORD_WAVE = 2'd2,
        ORD_RSVD = 2'd3
    } order_e;
endpackage

// File: rtl/sched_idx_cfg.sv
// Module: run configuration holder. Captures the bounds and the order when a
// start is accepted and keeps them stable for the whole run.
// Assumes: load_i is already qualified with the stall condition.
module sched_idx_cfg #(
    parameter int IDX_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic [IDX_W-1:0]          m_i,
    input  logic [IDX_W-1:0]          n_i,
    input  sched_idx_pkg::order_e     mode_i,
    output logic [IDX_W-1:0]          m_o,
    output logic [IDX_W-1:0]          n_o,
    output sched_idx_pkg::order_e     mode_o
);
    // Purpose: hold the bounds and the order of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_o    <= '0;
            n_o    <= '0;
            mode_o <= sched_idx_pkg::ORD_ROW;
        end else if (load_i) begin
            m_o    <= m_i;
            n_o    <= n_i;
            mode_o <= mode_i;
        end
    end
endmodule

// File: rtl/sched_idx_step.sv
// Module: combinational successor function. From the current pair it gives
// the next pair in the selected order and flags the final pair.
// Assumes: 1 <= i_i <= m_i and 1 <= j_i <= n_i; the caller ignores the
// successor of the final pair.
module sched_idx_step #(
    parameter int IDX_W = 8
) (
    input  sched_idx_pkg::order_e     mode_i,
    input  logic [IDX_W-1:0]          m_i,
    input  logic [IDX_W-1:0]          n_i,
    input  logic [IDX_W-1:0]          i_i,
    input  logic [IDX_W-1:0]          j_i,
    output logic [IDX_W-1:0]          i_o,
    output logic [IDX_W-1:0]          j_o,
    output logic                      last_o
);
    localparam int SUM_W = IDX_W + 1;

    logic [IDX_W-1:0] row_i, row_j, col_i, col_j, wav_i, wav_j;
    logic [SUM_W-1:0] diag_nx;
    logic [SUM_W-1:0] n_ext;

    // Purpose: the final pair is (M,N) in every order.
    assign last_o = (i_i == m_i) && (j_i == n_i);

    // Purpose: row order, with j fastest and a wrap to the next row.
    always_comb begin
        if (j_i < n_i) begin
            row_i = i_i;
            row_j = j_i + 1'b1;
        end else begin
            row_i = i_i + 1'b1;
            row_j = {{(IDX_W-1){1'b0}}, 1'b1};
        end
    end

    // Purpose: column order, with i fastest and a wrap to the next column.
    always_comb begin
        if (i_i < m_i) begin
            col_i = i_i + 1'b1;
            col_j = j_i;
        end else begin
            col_i = {{(IDX_W-1){1'b0}}, 1'b1};
            col_j = j_i + 1'b1;
        end
    end

    assign diag_nx = {1'b0, i_i} + {1'b0, j_i} + 1'b1;
    assign n_ext   = {1'b0, n_i};

    // Purpose: wavefront order. Move down the current diagonal, or jump
    // straight to the first in-range pair of the next diagonal.
    always_comb begin
        if ((i_i < m_i) && (j_i > 1)) begin
            wav_i = i_i + 1'b1;
            wav_j = j_i - 1'b1;
        end else if (diag_nx > n_ext) begin
            wav_i = IDX_W'(diag_nx - n_ext);
            wav_j = n_i;
        end else begin
            wav_i = {{(IDX_W-1){1'b0}}, 1'b1};
            wav_j = IDX_W'(diag_nx - 1'b1);
        end
    end

    // Purpose: pick the successor for the configured order.
    always_comb begin
        unique case (mode_i)
            sched_idx_pkg::ORD_COL:  begin i_o = col_i; j_o = col_j; end
            sched_idx_pkg::ORD_WAVE: begin i_o = wav_i; j_o = wav_j; end
            default:                 begin i_o = row_i; j_o = row_j; end
        endcase
    end
endmodule

// File: rtl/sched_idx_gen.sv
// Module: schedule-ordered 2-D iteration index generator (top). Issues one
// (i,j) pair per unstalled clock over 1..M by 1..N in row, column or
// wavefront order, and flags the final pair.
// Assumes: m_i and n_i are at least 1 when a start is accepted.
module sched_idx_gen #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stall_i,
    input  logic [1:0]       mode_i,
    input  logic [IDX_W-1:0] m_i,
    input  logic [IDX_W-1:0] n_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] i_o,
    output logic [IDX_W-1:0] j_o,
    output logic             done_o
);
    import sched_idx_pkg::*;

    logic             load;
    logic [IDX_W-1:0] m_q, n_q;
    order_e           mode_q;
    logic [IDX_W-1:0] i_q, j_q, i_nx, j_nx;
    logic             valid_q, last;

    assign load = start_i && !stall_i;

    sched_idx_cfg #(.IDX_W(IDX_W)) cfg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .m_i    (m_i),
        .n_i    (n_i),
        .mode_i (order_e'(mode_i)),
        .m_o    (m_q),
        .n_o    (n_q),
        .mode_o (mode_q)
    );

    sched_idx_step #(.IDX_W(IDX_W)) step_i (
        .mode_i (mode_q),
        .m_i    (m_q),
        .n_i    (n_q),
        .i_i    (i_q),
        .j_i    (j_q),
        .i_o    (i_nx),
        .j_o    (j_nx),
        .last_o (last)
    );

    // Purpose: current pair and valid flag; stall freezes, start restarts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            i_q     <= '0;
            j_q     <= '0;
        end else if (!stall_i) begin
            if (start_i) begin
                valid_q <= 1'b1;
                i_q     <= {{(IDX_W-1){1'b0}}, 1'b1};
                j_q     <= {{(IDX_W-1){1'b0}}, 1'b1};
            end else if (valid_q) begin
                if (last) begin
                    valid_q <= 1'b0;
                end else begin
                    i_q <= i_nx;
                    j_q <= j_nx;
                end
            end
        end
    end

    assign valid_o = valid_q;
    assign i_o     = i_q;
    assign j_o     = j_q;
    assign done_o  = valid_q && last;
endmodule

// File: rtl/sched_idx_gen_chk.sv
// Module: assertion checker for sched_idx_gen, bound to every instance.
// Keeps its own copy of the bounds and order taken at each accepted start.
// Assumes: accepted starts carry bounds of at least 1.
module sched_idx_gen_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             stall_i,
    input logic [1:0]       mode_i,
    input logic [IDX_W-1:0] m_i,
    input logic [IDX_W-1:0] n_i,
    input logic             valid_o,
    input logic [IDX_W-1:0] i_o,
    input logic [IDX_W-1:0] j_o,
    input logic             done_o
);
    logic [IDX_W-1:0] m_s, n_s;
    logic [1:0]       mode_s;
    logic [IDX_W:0]   sum_now;
    logic             step, row_like;

    // Purpose: shadow copy of the run configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_s <= '0; n_s <= '0; mode_s <= 2'd0;
        end else if (start_i && !stall_i) begin
            m_s <= m_i; n_s <= n_i; mode_s <= mode_i;
        end
    end

    assign sum_now  = {1'b0, i_o} + {1'b0, j_o};
    assign step     = valid_o && !stall_i && !start_i && !done_o;
    assign row_like = (mode_s == 2'd0) || (mode_s == 2'd3);

    p_first_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !stall_i |=> valid_o && i_o == 1 && j_o == 1);

    p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step && row_like |=> (i_o == $past(i_o) && j_o == $past(j_o) + 1'b1)
                          || (i_o == $past(i_o) + 1'b1 && j_o == 1));

    p_col_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step && mode_s == 2'd1 |=> (j_o == $past(j_o) && i_o == $past(i_o) + 1'b1)
                                || (j_o == $past(j_o) + 1'b1 && i_o == 1));

    p_wave_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step && mode_s == 2'd2 |=> (sum_now == $past(sum_now) && i_o == $past(i_o) + 1'b1)
                                || (sum_now == $past(sum_now) + 1'b1));

    p_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> i_o >= 1 && i_o <= m_s && j_o >= 1 && j_o <= n_s);

    p_done_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> valid_o && i_o == m_s && j_o == n_s);

    p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !stall_i && !start_i |=> !valid_o);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i && valid_o |=> valid_o && $stable(i_o) && $stable(j_o) && $stable(done_o));
endmodule

bind sched_idx_gen sched_idx_gen_chk #(.IDX_W(IDX_W)) chk_i (.*);

// File: tb/sched_idx_gen_tb.sv
module sched_idx_gen_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         stall_i = 1'b0;
    logic [1:0]   mode_i = 2'd0;
    logic [W-1:0] m_i = '0;
    logic [W-1:0] n_i = '0;
    logic         valid_o, done_o;
    logic [W-1:0] i_o, j_o;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_i [0:255];
    int exp_j [0:255];
    int exp_cnt;

    // Run table: order, M, N, index of pair at which to stall (-1 = none)
    localparam int NRUN = 8;
    localparam int T_MODE  [NRUN] = '{0, 1, 2, 2, 2, 3, 0, 2};
    localparam int T_M     [NRUN] = '{3, 4, 3, 5, 1, 2, 1, 4};
    localparam int T_N     [NRUN] = '{4, 3, 5, 2, 4, 3, 1, 4};
    localparam int T_STALL [NRUN] = '{-1, 5, 7, -1, -1, 2, -1, 9};

    always #4 clk = ~clk;

    sched_idx_gen #(.IDX_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stall_i(stall_i),
        .mode_i(mode_i), .m_i(m_i), .n_i(n_i),
        .valid_o(valid_o), .i_o(i_o), .j_o(j_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Expected order from the requirements (R3 row, R4 column, R5 wavefront, R6 reserved)
    task automatic build(input int mode, input int m, input int n);
        exp_cnt = 0;
        if (mode == 1) begin
            for (int j = 1; j <= n; j++)
                for (int i = 1; i <= m; i++) begin
                    exp_i[exp_cnt] = i; exp_j[exp_cnt] = j; exp_cnt++;
                end
        end else if (mode == 2) begin
            for (int s = 2; s <= m + n; s++)
                for (int i = 1; i <= m; i++)
                    if (s - i >= 1 && s - i <= n) begin
                        exp_i[exp_cnt] = i; exp_j[exp_cnt] = s - i; exp_cnt++;
                    end
        end else begin
            for (int i = 1; i <= m; i++)
                for (int j = 1; j <= n; j++) begin
                    exp_i[exp_cnt] = i; exp_j[exp_cnt] = j; exp_cnt++;
                end
        end
    endtask

    // One full run: start, then check every pair, done flag and the idle cycle.
    task automatic run_cfg(input int mode, input int m, input int n, input int stall_at);
        string req;
        req = (mode == 1) ? "R4" : (mode == 2) ? "R5" : (mode == 3) ? "R6" : "R3";
        build(mode, m, n);
        @(negedge clk);
        start_i = 1'b1; mode_i = 2'(mode); m_i = W'(m); n_i = W'(n);
        @(negedge clk);
        start_i = 1'b0;
        // R10: bounds and order inputs change during the run
        m_i = 8'd0; n_i = 8'd200; mode_i = 2'(mode + 1);
        check(valid_o && i_o == 1 && j_o == 1, "R2", "first pair (i*256+j)",
              int'(i_o) * 256 + int'(j_o), 257);
        for (int k = 0; k < exp_cnt; k++) begin
            check(valid_o, "R7", "valid during run", int'(valid_o), 1);
            check(int'(i_o) == exp_i[k] && int'(j_o) == exp_j[k], req,
                  "pair (i*256+j)", int'(i_o) * 256 + int'(j_o), exp_i[k] * 256 + exp_j[k]);
            check(done_o == (k == exp_cnt - 1), "R8", "done flag", int'(done_o),
                  int'(k == exp_cnt - 1));
            if (k == stall_at) begin
                stall_i = 1'b1; start_i = 1'b1;
                @(negedge clk);
                check(valid_o && int'(i_o) == exp_i[k] && int'(j_o) == exp_j[k], "R9",
                      "pair held under stall and start", int'(i_o) * 256 + int'(j_o),
                      exp_i[k] * 256 + exp_j[k]);
                stall_i = 1'b0; start_i = 1'b0;
            end
            @(negedge clk);
        end
        check(!valid_o && !done_o, "R8", "idle after final pair", int'(valid_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: run did not complete, actual 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!valid_o && !done_o, "R1", "valid/done in reset", int'(valid_o) + int'(done_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!valid_o && !done_o, "R1", "idle before start", int'(valid_o) + int'(done_o), 0);

        for (int r = 0; r < NRUN; r++)
            run_cfg(T_MODE[r], T_M[r], T_N[r], T_STALL[r]);

        // R2: a start during a run abandons it
        @(negedge clk);
        start_i = 1'b1; mode_i = 2'd0; m_i = 8'd3; n_i = 8'd3;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        check(valid_o && i_o == 2 && j_o == 1, "R2", "mid-run pair before restart",
              int'(i_o) * 256 + int'(j_o), 2 * 256 + 1);
        run_cfg(2, 2, 2, -1);

        // R9: stall in idle keeps the block idle and drops a start
        @(negedge clk);
        stall_i = 1'b1; start_i = 1'b1; mode_i = 2'd0; m_i = 8'd2; n_i = 8'd2;
        @(negedge clk);
        start_i = 1'b0; stall_i = 1'b0;
        @(negedge clk);
        check(!valid_o, "R9", "start ignored under stall", int'(valid_o), 0);

        summary();
        $finish;
    end
endmodule